// File: doc/BRIEF.md
# Calendar Counter with Alarm

This block is a register-mapped calendar clock. Seven byte-wide fields hold the year within a century, the month, the day of the month, the day of the week, and the hour, minute and second. The fields advance once for every pulse on a one-second tick input. A carry passes upward through the fields, and the length of each month is known, including the leap day in February.

A second bank of seven fields holds an alarm time. An alarm control register holds a global enable and one compare-enable bit per field. When a tick moves the calendar to a time where every enabled field equals its alarm field, a sticky status bit is set. The interrupt output is that status gated by the global enable, and software clears the status by writing a one to it. Software reaches both banks, the run/stop control, a small stored debounce setting and the status through a simple single-cycle register bus with combinational read data.

Top module: `calendar_alarm`

## Requirements
- R1: After reset the time bank reads year 0, month 1, day-of-month 1, day-of-week 0 and 00:00:00. The control register (0x20) reads 0x01 (stopped). Alarm control (0x7C), status (0x30) and `irq` are all 0.
- R2: With counting enabled, each tick adds one to the second. Second 59 wraps to 0 and carries into the minute, minute 59 wraps to 0 and carries into the hour, and hour 23 wraps to 0 and carries one day.
- R3: On each day carry the day-of-week field increments and wraps from 6 to 0.
- R4: On a day carry, the day-of-month returns to 1 after the last day of the month and carries into the month. Months 4, 6, 9 and 11 have 30 days, February is covered by R5, and all other months have 31. Month 12 wraps to 1 and carries into the year, and year 99 (parameter `YEAR_TOP`) wraps to 0.
- R5: February has 29 days when the year field is a nonzero multiple of 4. It has 28 days in year 0 and in all other years.
- R6: Bit 0 of the control register at 0x20 stops the calendar while it is 1: ticks are ignored and the time does not change. Clearing the bit lets the next tick advance the time.
- R7: The time field with index i (0 year, 1 month, 2 day-of-month, 3 day-of-week, 4 hour, 5 minute, 6 second) sits at byte address 0x40+4*i. A write loads the field and a read returns it. A write that lands in the same cycle as a tick takes priority, and that tick is dropped.
- R8: The alarm fields use the same index order at 0x60+4*i and read back what was written.
- R9: Alarm control at 0x7C: bit 0 is the global enable, and bit i+1 enables the compare of field i. Status (bit 4 of 0x30) is set after a tick that advances the time to a value in which every enabled field equals its alarm field. Disabled fields are ignored.
- R10: Status is sticky. Writing 1 to bit 4 of 0x30 clears it, and writing 0 leaves it set. If a set and a clear happen in the same cycle, the set wins.
- R11: `irq` is high exactly while status is set and alarm-control bit 0 is 1. Writing 0 to alarm control drops `irq` without clearing status, and no new status is raised while bit 0 is 0.
- R12: Bits [2:0] of 0x2C store a debounce setting that reads back unchanged. Its upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tick | input | 1 | One-second advance pulse |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with its default parameters, so the year wraps after 99 and all fields are one byte wide. Because any field can be loaded while the calendar is stopped, a single tick from a loaded instant reaches every roll-over: the century wrap, 30- and 31-day months, February in a leap year, in year 0 and in a common year, and a minute-only carry. The alarm scenarios cover masked fields, sticky status, write-one-to-clear, a set and a clear in the same cycle, and the gating of the interrupt by the global enable.

// File: rtl/cal_pkg.sv
package cal_pkg;

    // datapath geometry
    localparam int CAL_W   = 8;
    localparam int CAL_AW  = 8;
    localparam int NFLD    = 7;
    localparam int FIDX_W  = $clog2(NFLD);
    localparam int BANK_LSB = 5;
    localparam int DBNC_W  = 3;

    // field indices (order is the address order of both banks)
    localparam int F_YEAR = 0;
    localparam int F_MON  = 1;
    localparam int F_DOM  = 2;
    localparam int F_DOW  = 3;
    localparam int F_HOUR = 4;
    localparam int F_MIN  = 5;
    localparam int F_SEC  = 6;

    // register addresses
    localparam logic [CAL_AW-1:0] CAL_CTRL_ADDR   = CAL_AW'(8'h20);
    localparam logic [CAL_AW-1:0] CAL_DBNC_ADDR   = CAL_AW'(8'h2C);
    localparam logic [CAL_AW-1:0] CAL_INT_ADDR    = CAL_AW'(8'h30);
    localparam logic [CAL_AW-1:0] CAL_TIME_BASE   = CAL_AW'(8'h40);
    localparam logic [CAL_AW-1:0] CAL_ALARM_BASE  = CAL_AW'(8'h60);
    localparam logic [CAL_AW-1:0] CAL_ACTL_ADDR   = CAL_AW'(8'h7C);
    localparam int CTRL_STOP_BIT  = 0;
    localparam int INT_ALARM_BIT  = 4;
    localparam int ACTL_EN_BIT    = 0;

    // roll-over limits
    localparam logic [CAL_W-1:0] SEC_LAST  = CAL_W'(59);
    localparam logic [CAL_W-1:0] MIN_LAST  = CAL_W'(59);
    localparam logic [CAL_W-1:0] HOUR_LAST = CAL_W'(23);
    localparam logic [CAL_W-1:0] DOW_LAST  = CAL_W'(6);
    localparam logic [CAL_W-1:0] MON_LAST  = CAL_W'(12);
    localparam logic [CAL_W-1:0] ONE       = CAL_W'(1);

    typedef logic [NFLD-1:0][CAL_W-1:0] cal_fields_t;

    // index 6 (second) is the most significant slot
    localparam cal_fields_t CAL_RESET = {CAL_W'(0), CAL_W'(0), CAL_W'(0),
                                         CAL_W'(0), CAL_W'(1), CAL_W'(1),
                                         CAL_W'(0)};

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_DBNC,
        RS_INT,
        RS_TIME,
        RS_ALARM,
        RS_ACTL
    } cal_rsel_e;

    typedef struct packed {
        cal_rsel_e         kind;
        logic [FIDX_W-1:0] idx;
    } cal_dec_t;

    typedef struct packed {
        logic              wr;
        logic [CAL_AW-1:0] addr;
        logic [CAL_W-1:0]  data;
    } cal_bus_req_t;

    function automatic logic cal_is_leap(input logic [CAL_W-1:0] yr);
        return (yr[1:0] == 2'b00) && (yr != '0);
    endfunction

    function automatic logic [CAL_W-1:0] cal_month_len(input logic [CAL_W-1:0] mon,
                                                      input logic [CAL_W-1:0] yr);
        logic [CAL_W-1:0] len;
        case (mon)
            CAL_W'(2):  len = cal_is_leap(yr) ? CAL_W'(29) : CAL_W'(28);
            CAL_W'(4),
            CAL_W'(6),
            CAL_W'(9),
            CAL_W'(11): len = CAL_W'(30);
            default:    len = CAL_W'(31);
        endcase
        return len;
    endfunction

    // one-second step with carries; >= tolerates out-of-range loads
    function automatic cal_fields_t cal_advance(input cal_fields_t t,
                                                input logic [CAL_W-1:0] year_top);
        cal_fields_t n;
        logic        c;
        n = t;
        c = 1'b0;
        if (t[F_SEC] >= SEC_LAST) begin
            n[F_SEC] = '0;
            c = 1'b1;
        end else begin
            n[F_SEC] = t[F_SEC] + ONE;
        end
        if (c) begin
            if (t[F_MIN] >= MIN_LAST) begin
                n[F_MIN] = '0;
            end else begin
                n[F_MIN] = t[F_MIN] + ONE;
                c = 1'b0;
            end
        end
        if (c) begin
            if (t[F_HOUR] >= HOUR_LAST) begin
                n[F_HOUR] = '0;
            end else begin
                n[F_HOUR] = t[F_HOUR] + ONE;
                c = 1'b0;
            end
        end
        if (c) begin
            n[F_DOW] = (t[F_DOW] >= DOW_LAST) ? '0 : t[F_DOW] + ONE;
            if (t[F_DOM] >= cal_month_len(t[F_MON], t[F_YEAR])) begin
                n[F_DOM] = ONE;
            end else begin
                n[F_DOM] = t[F_DOM] + ONE;
                c = 1'b0;
            end
        end
        if (c) begin
            if (t[F_MON] >= MON_LAST) begin
                n[F_MON] = ONE;
            end else begin
                n[F_MON] = t[F_MON] + ONE;
                c = 1'b0;
            end
        end
        if (c) begin
            n[F_YEAR] = (t[F_YEAR] >= year_top) ? '0 : t[F_YEAR] + ONE;
        end
        return n;
    endfunction

    function automatic cal_dec_t cal_decode(input logic [CAL_AW-1:0] a);
        cal_dec_t d;
        d.kind = RS_NONE;
        d.idx  = a[FIDX_W+1:2];
        if (a[1:0] == 2'b00) begin
            if (a == CAL_CTRL_ADDR)
                d.kind = RS_CTRL;
            else if (a == CAL_DBNC_ADDR)
                d.kind = RS_DBNC;
            else if (a == CAL_INT_ADDR)
                d.kind = RS_INT;
            else if (a == CAL_ACTL_ADDR)
                d.kind = RS_ACTL;
            else if ((a[CAL_AW-1:BANK_LSB] == CAL_TIME_BASE[CAL_AW-1:BANK_LSB])
                     && (int'(d.idx) < NFLD))
                d.kind = RS_TIME;
            else if ((a[CAL_AW-1:BANK_LSB] == CAL_ALARM_BASE[CAL_AW-1:BANK_LSB])
                     && (int'(d.idx) < NFLD))
                d.kind = RS_ALARM;
        end
        return d;
    endfunction

endpackage

// File: rtl/cal_time_counter.sv
module cal_time_counter
    import cal_pkg::*;
#(
    parameter int YEAR_TOP = 99
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              stop,
    input  logic [NFLD-1:0]   fld_we,
    input  logic [CAL_W-1:0]  wdata,
    output cal_fields_t       time_q,
    output logic              stepped
);

    localparam logic [CAL_W-1:0] YTOP = CAL_W'(YEAR_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q  <= CAL_RESET;
            stepped <= 1'b0;
        end else begin
            stepped <= 1'b0;
            if (|fld_we) begin
                for (int i = 0; i < NFLD; i++) begin
                    if (fld_we[i])
                        time_q[i] <= wdata;
                end
            end else if (tick && !stop) begin
                time_q  <= cal_advance(time_q, YTOP);
                stepped <= 1'b1;
            end
        end
    end

    // R6: a stopped calendar with no field load keeps its time
    assert_stop_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (stop && !(|fld_we)) |=> $stable(time_q));

    // R2: a step from second 59 lands on second 0
    assert_sec_roll_R2: assert property (@(posedge clk) disable iff (rst)
        (stepped && ($past(time_q[F_SEC]) == SEC_LAST)) |-> (time_q[F_SEC] == '0));

    // R3: day-of-week leaving 6 goes to 0
    assert_dow_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (stepped && ($past(time_q[F_DOW]) == DOW_LAST)
         && (time_q[F_DOW] != $past(time_q[F_DOW]))) |-> (time_q[F_DOW] == '0));

    // R4: year leaving its top value goes to 0
    assert_year_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (stepped && ($past(time_q[F_YEAR]) == YTOP)
         && (time_q[F_YEAR] != $past(time_q[F_YEAR]))) |-> (time_q[F_YEAR] == '0));

endmodule

// File: rtl/cal_bus_regs.sv
module cal_bus_regs
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  cal_bus_req_t      req,
    input  cal_fields_t       time_q,
    input  logic              status,
    output logic              stop,
    output cal_fields_t       alarm_q,
    output logic [CAL_W-1:0]  actl,
    output logic [NFLD-1:0]   time_we,
    output logic              st_clr,
    output logic [CAL_W-1:0]  rdata
);

    cal_dec_t          dec;
    logic              wr_en;
    logic [DBNC_W-1:0] dbnc;

    assign dec   = cal_decode(req.addr);
    assign wr_en = sel && req.wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            stop    <= 1'b1;
            dbnc    <= '0;
            actl    <= '0;
            alarm_q <= '0;
        end else if (wr_en) begin
            case (dec.kind)
                RS_CTRL:  stop <= req.data[CTRL_STOP_BIT];
                RS_DBNC:  dbnc <= req.data[DBNC_W-1:0];
                RS_ACTL:  actl <= req.data;
                RS_ALARM: alarm_q[dec.idx] <= req.data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        time_we = '0;
        if (wr_en && (dec.kind == RS_TIME))
            time_we[dec.idx] = 1'b1;
    end

    assign st_clr = wr_en && (dec.kind == RS_INT) && req.data[INT_ALARM_BIT];

    always_comb begin
        rdata = '0;
        case (dec.kind)
            RS_CTRL:  rdata[CTRL_STOP_BIT] = stop;
            RS_DBNC:  rdata[DBNC_W-1:0] = dbnc;
            RS_INT:   rdata[INT_ALARM_BIT] = status;
            RS_TIME:  rdata = time_q[dec.idx];
            RS_ALARM: rdata = alarm_q[dec.idx];
            RS_ACTL:  rdata = actl;
            default:  rdata = '0;
        endcase
    end

    // R12: upper debounce bits never read as set
    assert_dbnc_hi_R12: assert property (@(posedge clk) disable iff (rst)
        (dec.kind == RS_DBNC) |-> (rdata[CAL_W-1:DBNC_W] == '0));

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cal_fields_t       time_q,
    input  cal_fields_t       alarm_q,
    input  logic [CAL_W-1:0]  actl,
    input  logic              stepped,
    input  logic              st_clr,
    output logic              status,
    output logic              irq
);

    logic [NFLD-1:0] fmatch;
    logic            hit;

    for (genvar g = 0; g < NFLD; g++) begin : g_cmp
        assign fmatch[g] = !actl[g+1] || (alarm_q[g] == time_q[g]);
    end

    assign hit = stepped && actl[ACTL_EN_BIT] && (&fmatch);

    always_ff @(posedge clk) begin
        if (rst)
            status <= 1'b0;
        else if (hit)
            status <= 1'b1;
        else if (st_clr)
            status <= 1'b0;
    end

    assign irq = status && actl[ACTL_EN_BIT];

    // R9: status only rises right after a calendar step
    assert_set_on_step_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(stepped));

    // R10: a clear with no step in that cycle empties status
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (st_clr && !stepped) |=> !status);

    // R10: status holds without a clear
    assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (status && !st_clr) |=> status);

endmodule

// File: rtl/calendar_alarm.sv
module calendar_alarm
    import cal_pkg::*;
#(
    parameter int YEAR_TOP = 99
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [CAL_AW-1:0] bus_addr,
    input  logic [CAL_W-1:0]  bus_wdata,
    output logic [CAL_W-1:0]  bus_rdata,
    input  logic              tick,
    output logic              irq
);

    cal_bus_req_t      req;
    cal_fields_t       time_q;
    cal_fields_t       alarm_q;
    logic [CAL_W-1:0]  actl;
    logic [NFLD-1:0]   time_we;
    logic              stop;
    logic              st_clr;
    logic              status;
    logic              stepped;

    assign req.wr   = bus_wr;
    assign req.addr = bus_addr;
    assign req.data = bus_wdata;

    cal_bus_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (bus_sel),
        .req     (req),
        .time_q  (time_q),
        .status  (status),
        .stop    (stop),
        .alarm_q (alarm_q),
        .actl    (actl),
        .time_we (time_we),
        .st_clr  (st_clr),
        .rdata   (bus_rdata)
    );

    cal_time_counter #(
        .YEAR_TOP (YEAR_TOP)
    ) u_count (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .stop    (stop),
        .fld_we  (time_we),
        .wdata   (bus_wdata),
        .time_q  (time_q),
        .stepped (stepped)
    );

    cal_alarm_match u_alarm (
        .clk     (clk),
        .rst     (rst),
        .time_q  (time_q),
        .alarm_q (alarm_q),
        .actl    (actl),
        .stepped (stepped),
        .st_clr  (st_clr),
        .status  (status),
        .irq     (irq)
    );

endmodule

// File: tb/test_calendar_alarm.sv
module test_calendar_alarm;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tick = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    calendar_alarm i_calendar_alarm (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick      (tick),
        .irq       (irq)
    );

    // address helpers: field i of time bank / alarm bank
    function automatic logic [7:0] ta(input int i);
        return 8'(8'h40 + 4 * i);
    endfunction
    function automatic logic [7:0] aa(input int i);
        return 8'(8'h60 + 4 * i);
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic load(input logic [7:0] y, mo, dm, dw, h, mi, s);
        wr(8'h20, 8'h01);
        wr(ta(0), y);  wr(ta(1), mo); wr(ta(2), dm); wr(ta(3), dw);
        wr(ta(4), h);  wr(ta(5), mi); wr(ta(6), s);
        wr(8'h20, 8'h00);
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 8'h20, 8'h01);
        rd_chk("R1 year", ta(0), 8'd0);
        rd_chk("R1 month", ta(1), 8'd1);
        rd_chk("R1 dom", ta(2), 8'd1);
        rd_chk("R1 dow", ta(3), 8'd0);
        rd_chk("R1 hour", ta(4), 8'd0);
        rd_chk("R1 sec", ta(6), 8'd0);
        rd_chk("R1 actl", 8'h7C, 8'h00);
        rd_chk("R1 status", 8'h30, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_century();
        load(8'd99, 8'd12, 8'd31, 8'd6, 8'd23, 8'd59, 8'd58);
        ticks(1);
        rd_chk("R2 sec step", ta(6), 8'd59);
        ticks(1);
        rd_chk("R2 sec wrap", ta(6), 8'd0);
        rd_chk("R2 min wrap", ta(5), 8'd0);
        rd_chk("R2 hour wrap", ta(4), 8'd0);
        rd_chk("R3 dow wrap", ta(3), 8'd0);
        rd_chk("R4 dom wrap", ta(2), 8'd1);
        rd_chk("R4 month wrap", ta(1), 8'd1);
        rd_chk("R4 year wrap", ta(0), 8'd0);
    endtask

    task automatic day_step(input string req, input logic [7:0] y, mo, dm,
                            input logic [7:0] ey, emo, edm);
        load(y, mo, dm, 8'd2, 8'd23, 8'd59, 8'd59);
        ticks(1);
        rd_chk({req, " dom"}, ta(2), edm);
        rd_chk({req, " month"}, ta(1), emo);
        rd_chk({req, " year"}, ta(0), ey);
        rd_chk("R3 dow inc", ta(3), 8'd3);
    endtask

    task automatic t_months();
        day_step("R4 apr30", 8'd21, 8'd4, 8'd30, 8'd21, 8'd5, 8'd1);
        day_step("R4 jan31", 8'd21, 8'd1, 8'd31, 8'd21, 8'd2, 8'd1);
        day_step("R4 jan30", 8'd21, 8'd1, 8'd30, 8'd21, 8'd1, 8'd31);
        day_step("R5 feb28 y24", 8'd24, 8'd2, 8'd28, 8'd24, 8'd2, 8'd29);
        day_step("R5 feb29 y24", 8'd24, 8'd2, 8'd29, 8'd24, 8'd3, 8'd1);
        day_step("R5 feb28 y0", 8'd0, 8'd2, 8'd28, 8'd0, 8'd3, 8'd1);
        day_step("R5 feb28 y23", 8'd23, 8'd2, 8'd28, 8'd23, 8'd3, 8'd1);
        load(8'd5, 8'd6, 8'd7, 8'd1, 8'd10, 8'd14, 8'd59);
        ticks(1);
        rd_chk("R2 min carry", ta(5), 8'd15);
        rd_chk("R2 hour kept", ta(4), 8'd10);
    endtask

    task automatic t_stop_and_load();
        load(8'd5, 8'd6, 8'd7, 8'd1, 8'd8, 8'd30, 8'd20);
        wr(8'h20, 8'h01);
        rd_chk("R6 ctrl set", 8'h20, 8'h01);
        ticks(3);
        rd_chk("R6 frozen", ta(6), 8'd20);
        wr(8'h20, 8'h00);
        ticks(1);
        rd_chk("R6 resumes", ta(6), 8'd21);
        // R7: write and tick in one cycle, write wins
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ta(6); bus_wdata = 8'd10; tick = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
        rd_chk("R7 write wins", ta(6), 8'd10);
        rd_chk("R7 min untouched", ta(5), 8'd30);
    endtask

    task automatic t_alarm_bank();
        for (int i = 0; i < 7; i++) wr(aa(i), 8'(8'h11 + i));
        for (int i = 0; i < 7; i++) rd_chk("R8 alarm field", aa(i), 8'(8'h11 + i));
    endtask

    task automatic arm_at_four();
        wr(8'h20, 8'h01);
        wr(ta(6), 8'd4);
        wr(8'h20, 8'h00);
    endtask

    task automatic t_alarm();
        load(8'd7, 8'd3, 8'd3, 8'd3, 8'd12, 8'd0, 8'd3);
        wr(aa(6), 8'd5);
        wr(aa(5), 8'd42);
        wr(8'h7C, 8'h81);            // enable + second compare only
        ticks(1);
        rd_chk("R9 no match yet", 8'h30, 8'h00);
        check("R11 irq low", {7'b0, irq}, 8'h00);
        ticks(1);
        rd_chk("R9 match sets", 8'h30, 8'h10);
        check("R11 irq high", {7'b0, irq}, 8'h01);
        ticks(1);
        rd_chk("R10 sticky", 8'h30, 8'h10);
        wr(8'h30, 8'h00);
        rd_chk("R10 write 0 keeps", 8'h30, 8'h10);
        wr(8'h30, 8'h10);
        rd_chk("R10 w1c", 8'h30, 8'h00);
        check("R11 irq after clear", {7'b0, irq}, 8'h00);
        // minute compare enabled too: mismatch blocks
        wr(8'h7C, 8'hC1);
        arm_at_four();
        ticks(1);
        rd_chk("R9 enabled field mismatch", 8'h30, 8'h00);
        // disable gating
        wr(8'h7C, 8'h81);
        arm_at_four();
        ticks(1);
        check("R11 irq on", {7'b0, irq}, 8'h01);
        wr(8'h7C, 8'h00);
        check("R11 irq gated", {7'b0, irq}, 8'h00);
        rd_chk("R11 status kept", 8'h30, 8'h10);
        wr(8'h30, 8'h10);
        arm_at_four();
        ticks(1);
        rd_chk("R11 no set when off", 8'h30, 8'h00);
        // set and clear in the same cycle
        wr(8'h7C, 8'h81);
        arm_at_four();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h30; bus_wdata = 8'h10;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd_chk("R10 set beats clear", 8'h30, 8'h10);
        wr(8'h30, 8'h10);
    endtask

    task automatic t_debounce();
        wr(8'h2C, 8'hFF);
        rd_chk("R12 masked", 8'h2C, 8'h07);
        wr(8'h2C, 8'h05);
        rd_chk("R12 readback", 8'h2C, 8'h05);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_century();
        t_months();
        t_stop_and_load();
        t_alarm_bank();
        t_alarm();
        t_debounce();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule